// File: doc/BRIEF.md
# Lane-Masked Single-Port Synchronous RAM

This block is a single-clock memory with one port that both reads and writes. Each access presents a port enable, an address, a write-data word and a write mask with one bit for each 9-bit lane of the word. A write replaces only the lanes whose mask bit is set. The other lanes of the addressed word, and every other word, are left untouched. Read data is registered and appears one clock after the enabled edge.

Each 9-bit lane is treated as one unit: 8 data bits plus 1 parity bit, stored and written together. A word of 18, 36 or 72 bits therefore holds 2, 4 or 8 lanes. An elaboration-time parameter sets what the output shows while a write is in progress:

- **Read-first:** the output shows the whole word as it was before the write.
- **Write-first:** the output shows the merged result of the write.

A synchronous reset clears only the output register and leaves the stored words alone.

Top module: `blram_lane_ram`

## Requirements
- R1: The word holds DATA_W/9 lanes (2 at 18 bits, 4 at 36, 8 at 72). Lane i occupies bits [9i+8:9i], so lane 0 is the least significant 9 bits, and mask bit i (`lane_we[i]`) controls lane i.
- R2: An enabled access with mask bits set writes the addressed word. Only the lanes with a set mask bit change. Unmasked lanes of that word and all other words keep their values.
- R3: An enabled access with an all-zero mask is a read. The stored word appears on `rd_data` after the next rising edge and stays there until the next enabled edge or reset.
- R4: In read-first mode (`MODE = RDW_READ_FIRST`), an enabled write puts the entire pre-write word on `rd_data` one clock later.
- R5: In write-first mode (`MODE = RDW_WRITE_FIRST`), an enabled write puts a merged word on `rd_data` one clock later: new data in the masked lanes and the old stored data in the others.
- R6: With `port_en` low, nothing is written whatever the mask, address or data, and `rd_data` holds its previous value.
- R7: A high `rst` at a rising edge sets `rd_data` to zero. Stored words are not changed by reset.
- R8: Back-to-back writes to one address on consecutive enabled edges each see the result of the previous write, both in memory and in the read-first and write-first outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| port_en | input | 1 | Port enable; low means no access of any kind |
| lane_we | input | DATA_W/9 | Per-lane write mask; all zero makes an enabled access a read |
| addr | input | $clog2(DEPTH) | Word address |
| wr_data | input | DATA_W | Write data, split into 9-bit lanes |
| rd_data | output | DATA_W | Registered read data |

## Verification
Two instances, one per read-during-write mode, receive identical stimulus and are compared against one shadow array in the bench.

Every address is first filled with a full-mask write. Then all sixteen mask values of the 4-lane configuration are applied to every address, with distinct per-lane data. The single-bit masks confirm that each lane lands in its own bit range. The partial masks separate the merged write-first output from the full old word of read-first.

Back-to-back writes to one address show whether the second access sees the first. Enable-low cycles with a full mask and new data, each followed by a read-back, tell a truly disabled port apart from one that still writes or updates its output. A reset in the middle of the run, followed by reads, shows that only the output register is cleared.

// File: rtl/blram_pkg.sv
package blram_pkg;

    localparam int LANE_W = 9;

    typedef enum logic {
        RDW_READ_FIRST  = 1'b0,
        RDW_WRITE_FIRST = 1'b1
    } rdw_mode_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic  wr;
        lane_t data;
    } lane_req_t;

    function automatic int lanes_for_width(input int width);
        return width / LANE_W;
    endfunction

    function automatic bit width_supported(input int width);
        return (width == 18) || (width == 36) || (width == 72);
    endfunction

endpackage

// File: rtl/blram_req_split.sv
module blram_req_split
    import blram_pkg::*;
#(
    parameter int DATA_W = 36,
    localparam int LANES = lanes_for_width(DATA_W)
) (
    input  logic [LANES-1:0]            lane_we,
    input  logic [DATA_W-1:0]           wr_data,
    output lane_req_t [LANES-1:0]       lane_req
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lane_req[i].wr   = lane_we[i];
            lane_req[i].data = wr_data[i*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/blram_lane_bank.sv
module blram_lane_bank
    import blram_pkg::*;
#(
    parameter int        DEPTH  = 256,
    parameter rdw_mode_e MODE   = RDW_WRITE_FIRST,
    localparam int       ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] addr,
    input  lane_req_t         req,
    output lane_t             dout
);

    lane_t store [DEPTH];
    lane_t old_word;
    lane_t next_out;

    assign old_word = store[addr];

    always_comb begin
        if (MODE == RDW_WRITE_FIRST && req.wr) begin
            next_out = req.data;
        end else begin
            next_out = old_word;
        end
    end

    // Storage: no reset, written only on an enabled, masked-in access.
    always_ff @(posedge clk) begin
        if (port_en && req.wr) begin
            store[addr] <= req.data;
        end
    end

    // Output register: cleared by reset, held while the port is off.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (port_en) begin
            dout <= next_out;
        end
    end

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> $stable(dout));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> dout == '0);

    // R3
    masked_off_shows_old_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en && !req.wr) |=> dout == $past(old_word));

    if (MODE == RDW_READ_FIRST) begin : g_rf_chk
        // R4
        read_first_old_chk: assert property (@(posedge clk) disable iff (rst)
            port_en |=> dout == $past(old_word));
    end else begin : g_wf_chk
        // R5
        write_first_new_chk: assert property (@(posedge clk) disable iff (rst)
            (port_en && req.wr) |=> dout == $past(req.data));
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en && req.wr) |=> store[$past(addr)] == $past(req.data));

endmodule

// File: rtl/blram_lane_ram.sv
module blram_lane_ram
    import blram_pkg::*;
#(
    parameter int        DATA_W = 36,
    parameter int        DEPTH  = 256,
    parameter rdw_mode_e MODE   = RDW_WRITE_FIRST,
    localparam int       LANES  = lanes_for_width(DATA_W),
    localparam int       ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    lane_req_t [LANES-1:0] lane_req;
    lane_t     [LANES-1:0] lane_out;

    blram_req_split #(
        .DATA_W (DATA_W)
    ) u_split (
        .lane_we  (lane_we),
        .wr_data  (wr_data),
        .lane_req (lane_req)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_bank
        blram_lane_bank #(
            .DEPTH (DEPTH),
            .MODE  (MODE)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .port_en (port_en),
            .addr    (addr),
            .req     (lane_req[i]),
            .dout    (lane_out[i])
        );
        assign rd_data[i*LANE_W +: LANE_W] = lane_out[i];
    end

    // R1
    initial begin
        lane_count_chk: assert (width_supported(DATA_W) && LANES * LANE_W == DATA_W);
    end

    // R6
    top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> $stable(rd_data));

endmodule

// File: tb/tb_blram_lane_ram.sv
module tb_blram_lane_ram;
    import blram_pkg::*;

    localparam int DW = 36;
    localparam int DEPTH = 16;
    localparam int LN = DW / 9;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          port_en = 1'b0;
    logic [LN-1:0] lane_we = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_wf;
    logic [DW-1:0] rd_rf;

    always #5 clk = ~clk;

    blram_lane_ram #(.DATA_W(DW), .DEPTH(DEPTH), .MODE(RDW_WRITE_FIRST)) dut (
        .clk(clk), .rst(rst), .port_en(port_en), .lane_we(lane_we),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_wf));

    blram_lane_ram #(.DATA_W(DW), .DEPTH(DEPTH), .MODE(RDW_READ_FIRST)) dut_rf (
        .clk(clk), .rst(rst), .port_en(port_en), .lane_we(lane_we),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_rf));

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] last_wf = '0;
    logic [DW-1:0] last_rf = '0;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk(input int a, input int p, input int k);
        logic [DW-1:0] v;
        for (int i = 0; i < LN; i++) v[i*9 +: 9] = 9'(a*37 + p*11 + k*5 + i*71 + 3);
        return v;
    endfunction

    task automatic do_op(input logic e, input logic [LN-1:0] w, input int a,
                         input logic [DW-1:0] d, input string tag, input bit chk_rf);
        logic [DW-1:0] old, mrg, exp_wf, exp_rf;
        @(negedge clk);
        port_en = e; lane_we = w; addr = AW'(a); wr_data = d;
        old = shadow[a];
        mrg = old;
        for (int i = 0; i < LN; i++) if (w[i]) mrg[i*9 +: 9] = d[i*9 +: 9];
        if (e) begin exp_wf = mrg; exp_rf = old; end
        else   begin exp_wf = last_wf; exp_rf = last_rf; end
        @(posedge clk); #1;
        if (e) shadow[a] = mrg;
        check(rd_wf, exp_wf, {tag, " write-first"});
        if (chk_rf) check(rd_rf, exp_rf, {tag, " read-first"});
        last_wf = exp_wf;
        last_rf = chk_rf ? exp_rf : rd_rf;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) shadow[a] = '0;
        repeat (2) @(posedge clk);
        #1;
        // R7 reset state
        check(rd_wf, '0, "R7 reset state");
        check(rd_rf, '0, "R7 reset state");
        @(negedge clk); rst = 1'b0;

        // Fill: full-mask writes (R2, R5); read-first old contents unknown
        for (int a = 0; a < DEPTH; a++) do_op(1'b1, '1, a, mk(a, 15, 0), "R2 fill", 1'b0);

        // All mask patterns at all addresses (R1, R2, R4, R5), then read back (R3)
        for (int p = 0; p < (1 << LN); p++) begin
            for (int a = 0; a < DEPTH; a++)
                do_op(1'b1, LN'(p), a, mk(a, p, 1),
                      ($countones(LN'(p)) == 1) ? "R1 lane mapping" : "R4 R5 mask sweep", 1'b1);
            for (int a = 0; a < DEPTH; a++) do_op(1'b1, '0, a, mk(a, p, 9), "R3 read-back", 1'b1);
        end

        // Back-to-back writes to one address (R8)
        for (int p = 1; p < (1 << LN); p++) do_op(1'b1, LN'(p), 5, mk(5, p, 2), "R8 back-to-back", 1'b1);
        do_op(1'b1, '0, 5, '0, "R8 final read", 1'b1);

        // Enable low: no write, output held (R6)
        for (int a = 0; a < DEPTH; a += 3) begin
            do_op(1'b1, '0, a, '0, "R6 pre-read", 1'b1);
            do_op(1'b0, '1, a, ~shadow[a], "R6 disabled write", 1'b1);
            do_op(1'b0, '0, (a + 1) % DEPTH, '0, "R6 disabled read", 1'b1);
            do_op(1'b1, '0, a, '0, "R6 memory unchanged", 1'b1);
        end

        // Reset mid-run: output cleared, memory kept (R7)
        do_op(1'b1, 4'b0110, 2, mk(2, 6, 3), "R7 pre-reset write", 1'b1);
        @(negedge clk); rst = 1'b1; port_en = 1'b0;
        @(posedge clk); #1;
        check(rd_wf, '0, "R7 reset clears output");
        check(rd_rf, '0, "R7 reset clears output");
        last_wf = '0; last_rf = '0;
        @(negedge clk); rst = 1'b0;
        for (int a = 0; a < DEPTH; a++) do_op(1'b1, '0, a, '0, "R7 memory kept", 1'b1);

        finish_run();
    end

endmodule